// File: doc/BRIEF.md
# Transmitter Equalization Command Responder

This block sits on the device side of a lane and acts on one-byte vendor margining commands that a host uses to tune the lane's transmitter. A command byte arrives with a one-cycle valid strobe. Its upper three bits pick an operation. The block keeps four transmitter settings: launch amplitude, edge rate, pre-cursor emphasis and post-cursor emphasis. A transmitter command steps one of these settings up or down by a 4-bit amount. The setting stops at its configured floor or ceiling, and the response reports when that happened.

A receiver adaptation command does not change any setting. It raises a one-cycle start pulse to the local receiver, then waits for that receiver's done signal. The block always returns a one-byte response: a 3-bit status, a limit flag and the amount echoed back. Reserved codes and malformed fields are refused with a NAK status and change nothing. Settings are 6-bit values. Each setting has its own floor, ceiling and reset default, all given as parameters.

Top module: `txeq_cmd_responder`

## Requirements
- R1: Command bits [7:5] select the target: 111 amplitude, 110 edge rate, 101 pre-emphasis, 100 post-emphasis. A transmitter command changes only the selected setting. Command bit [4] is the direction (1 up, 0 down) and bits [3:0] are the step.
- R2: After a transmitter command is accepted, the response status (bits [7:5]) is 001 (Setup) for exactly one cycle with the step echoed. The next cycle applies the update and the status becomes 000 (Finished).
- R3: An up-step that would pass the ceiling leaves the setting at the ceiling and sets response bit [4]. A step that lands exactly on the ceiling, or stays below it, adds the step and leaves bit [4] at 0.
- R4: A down-step that would pass below the floor leaves the setting at the floor and sets response bit [4]. A step that lands exactly on the floor, or stays above it, subtracts the step and leaves bit [4] at 0.
- R5: For transmitter commands, response bits [3:0] echo the command step in both Setup and Finished. For every other command they are 0000.
- R6: Command 001 with bits [4:0] all zero raises adapt_start for exactly one cycle. The status then stays 010 (In Progress) until adapt_done is seen high, and after that it reads 000.
- R7: Codes 010 and 011 give status 011 (NAK) with bits [4:0] zero, change no setting and raise no adapt_start.
- R8: Command 000 or 001 with a nonzero bit [4] or a nonzero step gives NAK, changes no setting and raises no adapt_start.
- R9: Command 000 with bits [4:0] zero gives a response of all zeros and changes no setting.
- R10: During reset and just after it, the settings hold their defaults, the response is zero and adapt_start is low.
- R11: A command strobed while the status is Setup or In Progress is ignored.
- R12: Each setting always lies between its floor and its ceiling, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe marking cmd_payload valid |
| cmd_payload | input | 8 | Command byte |
| adapt_done | input | 1 | Receiver adaptation has finished |
| tx_amp | output | PW | Amplitude setting |
| tx_slew | output | PW | Edge-rate setting |
| tx_pre | output | PW | Pre-cursor emphasis setting |
| tx_post | output | PW | Post-cursor emphasis setting |
| adapt_start | output | 1 | One-cycle request to start receiver adaptation |
| rsp_payload | output | 8 | Response byte: status, limit flag, echoed step |

## Verification
Two kinds of internal corruption can occur, and each shows at the ports:

- **Bad saturating adder or wrong slot selection.** A wrong sum, clamp or lane select shows on the setting outputs and on the limit flag one cycle after Setup, at the edge where the update is committed.
- **Wrong status state.** The status field shows the error in the first cycle after the strobe. Examples are a Setup that lasts too long, a lost In Progress, or a NAK that did not block a write.

Sweeping every step size in both directions on every slot walks each setting into both of its limits and onto both of them exactly. Because of that, an off-by-one in a limit comparison changes the flag or the value at the first command that reaches that limit.

// File: rtl/txeq_pkg.sv
// Shared definitions for the transmitter equalization command responder.
// Assumes the fixed one-byte command and response layout: 3-bit opcode or
// status, one direction or limit bit, and a 4-bit step.
package txeq_pkg;

    localparam int unsigned NUM_PARAMS = 4;
    localparam int unsigned SEL_W      = 2;
    localparam int unsigned STEP_W     = 4;

    // Response status codes carried in response bits [7:5].
    typedef enum logic [2:0] {
        ST_FINISHED = 3'b000,
        ST_SETUP    = 3'b001,
        ST_BUSY     = 3'b010,
        ST_NAK      = 3'b011
    } rsp_status_e;

    // Classification of an incoming command.
    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_TX    = 2'd1,
        K_ADAPT = 2'd2,
        K_BAD   = 2'd3
    } cmd_kind_e;

    // Decoded command fields.
    typedef struct packed {
        cmd_kind_e            kind;
        logic [SEL_W-1:0]     sel;   // 3 amplitude, 2 edge rate, 1 pre, 0 post
        logic                 up;
        logic [STEP_W-1:0]    step;
    } cmd_dec_t;

endpackage

// File: rtl/txeq_cmd_decode.sv
// Combinational command classifier.
// Opcodes with bit 7 set are transmitter steps, and the low two opcode bits
// pick the setting slot. Opcode 001 is an adaptation request and 000 is a
// no-op. Both are valid only when bits [4:0] are zero. The remaining codes
// are reserved.
module txeq_cmd_decode
    import txeq_pkg::*;
(
    input  logic [7:0] payload,
    output cmd_dec_t   dec
);

    logic [2:0] opcode;
    logic       extra_bits;

    assign opcode     = payload[7:5];
    assign extra_bits = |payload[4:0];

    // Map the opcode and field check onto a command kind.
    always_comb begin
        dec.sel  = opcode[1:0];
        dec.up   = payload[4];
        dec.step = payload[3:0];
        if (opcode[2]) begin
            dec.kind = K_TX;
        end else begin
            case (opcode[1:0])
                2'b00:   dec.kind = extra_bits ? K_BAD : K_NONE;
                2'b01:   dec.kind = extra_bits ? K_BAD : K_ADAPT;
                default: dec.kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/txeq_param_bank.sv
// Bank of transmitter settings with saturating step updates.
// Each slot has its own floor, ceiling and reset value, packed slot 0 at the
// LSBs. The limit flag for the selected slot is computed from its current
// value and the step, and is valid in the cycle that apply is high.
// Assumes PW >= STEP_W and that every default lies within its limits.
module txeq_param_bank
    import txeq_pkg::*;
#(
    parameter int unsigned PW = 6,
    parameter int unsigned NP = NUM_PARAMS,
    parameter logic [NP*PW-1:0] P_MIN = '0,
    parameter logic [NP*PW-1:0] P_MAX = '1,
    parameter logic [NP*PW-1:0] P_DEF = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 apply,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 up,
    input  logic [STEP_W-1:0]    step,
    output logic [NP*PW-1:0]     params,
    output logic                 hit
);

    localparam int unsigned XW = PW + 1;

    logic [XW-1:0] step_x;
    logic [NP-1:0] lane_hit;

    assign step_x = {{(XW-STEP_W){1'b0}}, step};

    for (genvar gi = 0; gi < NP; gi++) begin : g_slot
        localparam logic [PW-1:0] LMIN = P_MIN[gi*PW +: PW];
        localparam logic [PW-1:0] LMAX = P_MAX[gi*PW +: PW];
        localparam logic [PW-1:0] LDEF = P_DEF[gi*PW +: PW];

        logic [PW-1:0] cur;
        logic [PW-1:0] nxt;
        logic [XW-1:0] sum_up;
        logic [XW-1:0] floor_plus;
        logic          clip;

        // Compute the clamped next value and whether clamping occurred.
        always_comb begin
            sum_up     = {1'b0, cur} + step_x;
            floor_plus = {1'b0, LMIN} + step_x;
            if (up) begin
                clip = sum_up > {1'b0, LMAX};
                nxt  = clip ? LMAX : sum_up[PW-1:0];
            end else begin
                clip = {1'b0, cur} < floor_plus;
                nxt  = clip ? LMIN : (cur - step_x[PW-1:0]);
            end
        end

        // Hold the setting and commit the step when this slot is chosen.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur <= LDEF;
            end else if (apply && (sel == SEL_W'(gi))) begin
                cur <= nxt;
            end
        end

        assign params[gi*PW +: PW] = cur;
        assign lane_hit[gi]        = clip;
    end

    assign hit = lane_hit[sel];

endmodule

// File: rtl/txeq_resp_fsm.sv
// Response sequencer.
// A command is accepted only while the status is Finished or NAK. A
// transmitter step goes through one Setup cycle, and in that cycle apply is
// high and the latched fields drive the parameter bank. An adaptation request
// pulses adapt_start and holds In Progress until adapt_done.
module txeq_resp_fsm
    import txeq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  cmd_dec_t            dec,
    input  logic                hit,
    input  logic                adapt_done,
    output logic                apply,
    output logic [SEL_W-1:0]    sel,
    output logic                up,
    output logic [STEP_W-1:0]   step,
    output logic                adapt_start,
    output logic [7:0]          rsp
);

    rsp_status_e        status;
    logic               rsp_flag;
    logic [STEP_W-1:0]  rsp_step;
    logic               accept;

    assign accept = cmd_valid && ((status == ST_FINISHED) || (status == ST_NAK));
    assign apply  = (status == ST_SETUP);

    // Status, response fields and latched command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status      <= ST_FINISHED;
            rsp_flag    <= 1'b0;
            rsp_step    <= '0;
            sel         <= '0;
            up          <= 1'b0;
            step        <= '0;
            adapt_start <= 1'b0;
        end else begin
            adapt_start <= 1'b0;
            if (accept) begin
                rsp_flag <= 1'b0;
                rsp_step <= '0;
                case (dec.kind)
                    K_TX: begin
                        status   <= ST_SETUP;
                        rsp_step <= dec.step;
                        sel      <= dec.sel;
                        up       <= dec.up;
                        step     <= dec.step;
                    end
                    K_ADAPT: begin
                        status      <= ST_BUSY;
                        adapt_start <= 1'b1;
                    end
                    K_NONE:  status <= ST_FINISHED;
                    default: status <= ST_NAK;
                endcase
            end else if (status == ST_SETUP) begin
                status   <= ST_FINISHED;
                rsp_flag <= hit;
            end else if ((status == ST_BUSY) && adapt_done) begin
                status <= ST_FINISHED;
            end
        end
    end

    assign rsp = {status, rsp_flag, rsp_step};

endmodule

// File: rtl/txeq_cmd_responder.sv
// Top of the transmitter equalization command responder.
// Decodes the command byte, sequences the response and owns the four
// transmitter settings. Slot order inside the bank matches the low two
// opcode bits: 3 amplitude, 2 edge rate, 1 pre-emphasis, 0 post-emphasis.
module txeq_cmd_responder
    import txeq_pkg::*;
#(
    parameter int unsigned PW = 6,
    parameter logic [NUM_PARAMS*PW-1:0] P_MIN = {6'd2,  6'd1,  6'd0,  6'd3},
    parameter logic [NUM_PARAMS*PW-1:0] P_MAX = {6'd60, 6'd50, 6'd40, 6'd45},
    parameter logic [NUM_PARAMS*PW-1:0] P_DEF = {6'd32, 6'd20, 6'd10, 6'd12}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_payload,
    input  logic          adapt_done,
    output logic [PW-1:0] tx_amp,
    output logic [PW-1:0] tx_slew,
    output logic [PW-1:0] tx_pre,
    output logic [PW-1:0] tx_post,
    output logic          adapt_start,
    output logic [7:0]    rsp_payload
);

    localparam int unsigned NP = NUM_PARAMS;

    cmd_dec_t             dec;
    logic                 apply;
    logic [SEL_W-1:0]     sel;
    logic                 up;
    logic [STEP_W-1:0]    step;
    logic                 hit;
    logic [NP*PW-1:0]     params;

    txeq_cmd_decode u_decode (
        .payload (cmd_payload),
        .dec     (dec)
    );

    txeq_resp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .dec         (dec),
        .hit         (hit),
        .adapt_done  (adapt_done),
        .apply       (apply),
        .sel         (sel),
        .up          (up),
        .step        (step),
        .adapt_start (adapt_start),
        .rsp         (rsp_payload)
    );

    txeq_param_bank #(
        .PW    (PW),
        .NP    (NP),
        .P_MIN (P_MIN),
        .P_MAX (P_MAX),
        .P_DEF (P_DEF)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply  (apply),
        .sel    (sel),
        .up     (up),
        .step   (step),
        .params (params),
        .hit    (hit)
    );

    assign tx_post = params[0*PW +: PW];
    assign tx_pre  = params[1*PW +: PW];
    assign tx_slew = params[2*PW +: PW];
    assign tx_amp  = params[3*PW +: PW];

endmodule

// File: rtl/txeq_cmd_responder_chk.sv
// Port-level property checker for the command responder, bound to the top.
// Assumes the same parameter values as the bound instance.
module txeq_cmd_responder_chk #(
    parameter int unsigned PW = 6,
    parameter logic [4*PW-1:0] P_MIN = '0,
    parameter logic [4*PW-1:0] P_MAX = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [7:0]    cmd_payload,
    input logic          adapt_done,
    input logic [PW-1:0] tx_amp,
    input logic [PW-1:0] tx_slew,
    input logic [PW-1:0] tx_pre,
    input logic [PW-1:0] tx_post,
    input logic          adapt_start,
    input logic [7:0]    rsp_payload
);

    localparam logic [PW-1:0] POST_MIN = P_MIN[0*PW +: PW];
    localparam logic [PW-1:0] PRE_MIN  = P_MIN[1*PW +: PW];
    localparam logic [PW-1:0] SLEW_MIN = P_MIN[2*PW +: PW];
    localparam logic [PW-1:0] AMP_MIN  = P_MIN[3*PW +: PW];
    localparam logic [PW-1:0] POST_MAX = P_MAX[0*PW +: PW];
    localparam logic [PW-1:0] PRE_MAX  = P_MAX[1*PW +: PW];
    localparam logic [PW-1:0] SLEW_MAX = P_MAX[2*PW +: PW];
    localparam logic [PW-1:0] AMP_MAX  = P_MAX[3*PW +: PW];

    logic [2:0] st;
    assign st = rsp_payload[7:5];

    a_r2_setup_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'b001) |=> (st == 3'b000));

    a_r5_echo_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'b001) |=> (rsp_payload[3:0] == $past(rsp_payload[3:0])));

    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        adapt_start |=> !adapt_start);

    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        adapt_start |-> (st == 3'b010));

    a_r3_flag_finished_only: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_payload[4] |-> (st == 3'b000));

    a_r7_nak_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'b011) |-> (rsp_payload[4:0] == 5'd0));

    a_r11_hold_outside_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 3'b001) |=> ($stable(tx_amp) && $stable(tx_slew)
                            && $stable(tx_pre) && $stable(tx_post)));

    a_r12_amp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_amp >= AMP_MIN) && (tx_amp <= AMP_MAX));

    a_r12_slew_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_slew >= SLEW_MIN) && (tx_slew <= SLEW_MAX));

    a_r12_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pre >= PRE_MIN) && (tx_pre <= PRE_MAX));

    a_r12_post_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_post >= POST_MIN) && (tx_post <= POST_MAX));

endmodule

bind txeq_cmd_responder txeq_cmd_responder_chk #(
    .PW    (PW),
    .P_MIN (P_MIN),
    .P_MAX (P_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_payload (cmd_payload),
    .adapt_done  (adapt_done),
    .tx_amp      (tx_amp),
    .tx_slew     (tx_slew),
    .tx_pre      (tx_pre),
    .tx_post     (tx_post),
    .adapt_start (adapt_start),
    .rsp_payload (rsp_payload)
);

// File: tb/txeq_cmd_responder_bench.sv
`timescale 1ns/1ps
// Self-checking bench. It sweeps every step in both directions on each
// slot, runs exact-landing sequences, all reserved and malformed codes, an
// adaptation handshake and commands issued while busy.
module txeq_cmd_responder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_payload = 8'h00;
    logic       adapt_done = 1'b0;
    logic [5:0] tx_amp, tx_slew, tx_pre, tx_post;
    logic       adapt_start;
    logic [7:0] rsp_payload;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench configuration, slot 0 post, 1 pre, 2 edge rate, 3 amplitude.
    int mn[4]  = '{3, 0, 1, 2};
    int mx[4]  = '{45, 40, 50, 60};
    int df[4]  = '{12, 10, 20, 32};
    int exp_v[4];

    always #2.5 clk = ~clk;

    txeq_cmd_responder u_txeq_cmd_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_payload (cmd_payload),
        .adapt_done  (adapt_done),
        .tx_amp      (tx_amp),
        .tx_slew     (tx_slew),
        .tx_pre      (tx_pre),
        .tx_post     (tx_post),
        .adapt_start (adapt_start),
        .rsp_payload (rsp_payload)
    );

    task automatic check(input string req, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_params(input string req);
        check({req, " post"}, int'(tx_post), exp_v[0]);
        check({req, " pre"},  int'(tx_pre),  exp_v[1]);
        check({req, " slew"}, int'(tx_slew), exp_v[2]);
        check({req, " amp"},  int'(tx_amp),  exp_v[3]);
    endtask

    // Send one transmitter step and check Setup, then Finished (R1..R5).
    task automatic send_tx(input int sel, input bit up, input int amt);
        int nv;
        int hit;
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_payload = {1'b1, 2'(sel), up, 4'(amt)};
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 setup rsp", int'(rsp_payload), (1 << 5) | amt);
        check_params("R11 unchanged in setup");
        @(negedge clk);
        hit = 0;
        if (up) begin
            nv = exp_v[sel] + amt;
            if (nv > mx[sel]) begin nv = mx[sel]; hit = 1; end
        end else begin
            nv = exp_v[sel] - amt;
            if (nv < mn[sel]) begin nv = mn[sel]; hit = 1; end
        end
        exp_v[sel] = nv;
        check(up ? "R3 finished rsp" : "R4 finished rsp", int'(rsp_payload), (hit << 4) | amt);
        check("R5 echo", int'(rsp_payload[3:0]), amt);
        check_params("R1 settings");
    endtask

    // Send a non-transmitter byte expected to produce a one-cycle response.
    task automatic send_other(input logic [7:0] b, input int exp_rsp, input string req);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_payload = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(req, int'(rsp_payload), exp_rsp);
        check({req, " no start"}, int'(adapt_start), 0);
        check_params(req);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_v[i] = df[i];
        repeat (3) @(negedge clk);
        // R10: state while reset is held.
        check("R10 rsp in reset", int'(rsp_payload), 0);
        check_params("R10 defaults in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 rsp", int'(rsp_payload), 0);
        check("R10 start", int'(adapt_start), 0);
        check_params("R10 defaults");

        // Sweep every slot, both directions, every step, then exact landings.
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 16; a++) send_tx(s, 1'b1, a);
            for (int a = 0; a < 16; a++) send_tx(s, 1'b0, a);
            while (exp_v[s] < mx[s]) send_tx(s, 1'b1, (mx[s] - exp_v[s] > 15) ? 15 : mx[s] - exp_v[s]);
            send_tx(s, 1'b1, 1);
            while (exp_v[s] > mn[s]) send_tx(s, 1'b0, (exp_v[s] - mn[s] > 15) ? 15 : exp_v[s] - mn[s]);
            send_tx(s, 1'b0, 1);
            send_tx(s, 1'b1, 7);
        end

        // R7: reserved codes with every low-field pattern.
        for (int op = 2; op < 4; op++)
            for (int lo = 0; lo < 32; lo++)
                send_other({3'(op), 5'(lo)}, 3 << 5, "R7 reserved nak");
        // R8: malformed no-op and adaptation bytes; R9: clean no-op.
        for (int lo = 1; lo < 32; lo++) begin
            send_other({3'b000, 5'(lo)}, 3 << 5, "R8 noop fields nak");
            send_other({3'b001, 5'(lo)}, 3 << 5, "R8 adapt fields nak");
        end
        send_other(8'h00, 0, "R9 noop");
        send_tx(3, 1'b1, 2);

        // R6: adaptation handshake, with an ignored command while busy (R11).
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_payload = 8'h20;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R6 start pulse", int'(adapt_start), 1);
        check("R6 in progress", int'(rsp_payload), 2 << 5);
        @(negedge clk);
        check("R6 pulse ends", int'(adapt_start), 0);
        check("R6 still busy", int'(rsp_payload), 2 << 5);
        cmd_valid   = 1'b1;
        cmd_payload = 8'hFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 busy ignores cmd", int'(rsp_payload), 2 << 5);
        check_params("R11 busy settings");
        adapt_done = 1'b1;
        @(negedge clk);
        adapt_done = 1'b0;
        check("R6 finished", int'(rsp_payload), 0);
        check("R6 no second pulse", int'(adapt_start), 0);

        // R11: a second strobe during Setup is dropped.
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_payload = {3'b110, 1'b1, 4'd3};
        @(negedge clk);
        cmd_payload = {3'b100, 1'b1, 4'd9};
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_v[2] = exp_v[2] + 3;
        check("R11 setup ignores cmd", int'(rsp_payload), 3);
        check_params("R11 setup settings");
        @(negedge clk);
        check("R11 no late setup", int'(rsp_payload), 3);
        check_params("R11 after setup");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule